// File: doc/BRIEF.md
# Receive Buffer Acceptance Filter

This block decides which receive message buffer takes a frame that has just arrived on a dual-channel, time-triggered bus. It keeps a small table of buffer settings: a direction bit, an active flag, a slot number, a segment kind (static or dynamic) and a two-bit channel mask. For every completed frame, the receive path presents the slot number, the channel it came in on, the current segment and a validity flag. One cycle later the block reports whether a buffer accepted the frame and, if so, which one.

Software fills a staging register with the fields of one buffer and then issues a commit command that names the target buffer. The commit copies the staged fields into that table entry and makes the entry active. A static buffer may listen on both channels. Such a buffer keeps only the first valid copy of its slot's frame and ignores the redundant copy from the other channel until the next slot boundary. When several buffers qualify, the lowest buffer number wins.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, `hit` and `hit_idx` are 0 and every table entry is inactive, so no frame is accepted until an entry has been committed.
- R2: A one-cycle `cmd_valid` copies the staged fields into entry `cmd_buf` and marks it active. The change applies from the next cycle on, so a frame presented in the same cycle as the commit is judged against the old table. A `cmd_buf` of `NBUF` or more is ignored.
- R3: `stg_wr` only loads the staging register. Until a commit follows, staged values have no effect on acceptance.
- R4: An entry whose direction bit is 1 (transmit) never accepts a frame.
- R5: An entry matches a frame when all three of these hold: its slot equals `frm_slot`; its segment bit equals `frm_dyn` (0 = static, 1 = dynamic); and its channel mask has the bit for `frm_chan` set. In the mask, bit 0 is channel A and bit 1 is channel B. On `frm_chan`, 0 means A and 1 means B.
- R6: A dynamic entry whose mask is 2'b11 is an illegal setting and accepts no frame. A mask of 2'b00 accepts no frame in either segment.
- R7: A static entry with mask 2'b11 accepts the first valid frame of its slot. It then ignores further frames until `slot_start` is pulsed. A `slot_start` in the same cycle as a frame clears this state before that frame is judged.
- R8: When several entries qualify, the lowest index wins. A both-channel static entry that has already taken its frame does not qualify, so the next matching entry can win.
- R9: A frame with `frm_ok` low never produces a hit and does not mark a both-channel entry as taken.
- R10: `hit` is high for exactly the one cycle after a `frm_valid` cycle that found a winner. Otherwise it is low, and `hit_idx` is 0 whenever `hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_wr | input | 1 | Load the staging register |
| stg_dir | input | 1 | Staged direction (0 = receive) |
| stg_slot | input | SLOT_W | Staged slot number |
| stg_dyn | input | 1 | Staged segment kind (1 = dynamic) |
| stg_chan | input | 2 | Staged channel mask (bit0 A, bit1 B) |
| cmd_valid | input | 1 | Commit staging into an entry |
| cmd_buf | input | IDX_W | Entry number for the commit |
| slot_start | input | 1 | Slot boundary pulse |
| frm_valid | input | 1 | A frame has completed this cycle |
| frm_ok | input | 1 | Frame is semantically valid |
| frm_slot | input | SLOT_W | Slot number of the frame |
| frm_chan | input | 1 | Channel of the frame (0 A, 1 B) |
| frm_dyn | input | 1 | Frame in dynamic segment |
| hit | output | 1 | A buffer accepted the last frame |
| hit_idx | output | IDX_W | Index of the accepting buffer |

## Verification
A corrupted table entry or staging register shows up at the ports on the first frame aimed at that slot. One cycle after that frame, `hit` or `hit_idx` is wrong. A stuck or uncleared taken bit stays hidden until the redundant copy arrives on the second channel, or until the first frame of the next slot. The random mix therefore uses a small slot range and frequent slot boundaries, so that every entry is probed within a few cycles of each change.

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int NBUF   = 8,
  parameter int SLOT_W = 11,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_wr,
  input  logic              stg_dir,
  input  logic [SLOT_W-1:0] stg_slot,
  input  logic              stg_dyn,
  input  logic [1:0]        stg_chan,
  input  logic              cmd_valid,
  input  logic [IDX_W-1:0]  cmd_buf,
  input  logic              slot_start,
  input  logic              frm_valid,
  input  logic              frm_ok,
  input  logic [SLOT_W-1:0] frm_slot,
  input  logic              frm_chan,
  input  logic              frm_dyn,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  logic              s_dir, s_dyn;
  logic [SLOT_W-1:0] s_slot;
  logic [1:0]        s_chan;

  logic [NBUF-1:0]   act, dir, dyn, taken;
  logic [SLOT_W-1:0] slot [NBUF];
  logic [1:0]        chan [NBUF];

  logic [NBUF-1:0]   elig;
  logic [NBUF-1:0]   taken_eff;
  logic              any;
  logic [IDX_W-1:0]  win;
  logic              accept;
  logic              cmd_ok;

  assign taken_eff = slot_start ? '0 : taken;
  assign cmd_ok    = cmd_valid && (int'(cmd_buf) < NBUF);

  for (genvar i = 0; i < NBUF; i++) begin : g_ent
    logic both;
    assign both    = &chan[i];
    assign elig[i] = act[i] && !dir[i] && (slot[i] == frm_slot) &&
                     (dyn[i] == frm_dyn) && chan[i][frm_chan] &&
                     !(dyn[i] && both) && !(!dyn[i] && both && taken_eff[i]);
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        win = IDX_W'(i);
      end
    end
  end

  assign accept = frm_valid && frm_ok && any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_dir  <= 1'b0;
      s_dyn  <= 1'b0;
      s_slot <= '0;
      s_chan <= '0;
    end else if (stg_wr) begin
      s_dir  <= stg_dir;
      s_dyn  <= stg_dyn;
      s_slot <= stg_slot;
      s_chan <= stg_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      dir <= '0;
      dyn <= '0;
      for (int i = 0; i < NBUF; i++) begin
        slot[i] <= '0;
        chan[i] <= '0;
      end
    end else if (cmd_ok) begin
      act[cmd_buf]  <= 1'b1;
      dir[cmd_buf]  <= s_dir;
      dyn[cmd_buf]  <= s_dyn;
      slot[cmd_buf] <= s_slot;
      chan[cmd_buf] <= s_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken <= '0;
    end else begin
      taken <= taken_eff;
      if (accept && !dyn[win] && (&chan[win]))
        taken[win] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit     <= accept;
      hit_idx <= accept ? win : '0;
    end
  end

  // R10
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_idx == '0);

  // R10
  hit_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !hit);

  // R9
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ok) |=> !hit);

  // R7
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !frm_valid) |=> taken == '0);

  // R2
  commit_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> act[$past(cmd_buf)]);

  // R7
  taken_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(taken[0]) |-> !dyn[0] && (&chan[0]));

endmodule

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;
  localparam int NBUF = 8, SLOT_W = 11, IDX_W = 3;

  logic clk = 0, rst_n = 0;
  logic stg_wr = 0, stg_dir = 0, stg_dyn = 0;
  logic [SLOT_W-1:0] stg_slot = '0, frm_slot = '0;
  logic [1:0] stg_chan = '0;
  logic cmd_valid = 0;
  logic [IDX_W-1:0] cmd_buf = '0;
  logic slot_start = 0, frm_valid = 0, frm_ok = 0, frm_chan = 0, frm_dyn = 0;
  logic hit;
  logic [IDX_W-1:0] hit_idx;

  int vectors = 0, errors = 0;

  always #10 clk = ~clk;

  rx_accept_filter #(.NBUF(NBUF), .SLOT_W(SLOT_W)) uut (
    .clk, .rst_n, .stg_wr, .stg_dir, .stg_slot, .stg_dyn, .stg_chan,
    .cmd_valid, .cmd_buf, .slot_start, .frm_valid, .frm_ok, .frm_slot,
    .frm_chan, .frm_dyn, .hit, .hit_idx);

  logic m_sdir, m_sdyn;
  logic [SLOT_W-1:0] m_sslot;
  logic [1:0] m_schan;
  logic m_act[NBUF], m_dir[NBUF], m_dyn[NBUF], m_tk[NBUF];
  logic [SLOT_W-1:0] m_slot[NBUF];
  logic [1:0] m_chan[NBUF];

  function automatic void m_reset();
    m_sdir = 0; m_sdyn = 0; m_sslot = '0; m_schan = '0;
    for (int i = 0; i < NBUF; i++) begin
      m_act[i] = 0; m_dir[i] = 0; m_dyn[i] = 0; m_tk[i] = 0;
      m_slot[i] = '0; m_chan[i] = '0;
    end
  endfunction

  function automatic int m_winner();
    for (int i = 0; i < NBUF; i++) begin
      logic both = m_chan[i] == 2'b11;
      if (m_act[i] && !m_dir[i] && m_slot[i] == frm_slot && m_dyn[i] == frm_dyn &&
          m_chan[i][frm_chan] && !(m_dyn[i] && both) &&
          !(!m_dyn[i] && both && m_tk[i] && !slot_start))
        return i;
    end
    return -1;
  endfunction

  task automatic cyc(string tag);
    int w;
    logic e_hit;
    logic [IDX_W-1:0] e_idx;
    w = m_winner();
    e_hit = frm_valid && frm_ok && (w >= 0);
    e_idx = e_hit ? IDX_W'(w) : '0;
    if (slot_start) for (int i = 0; i < NBUF; i++) m_tk[i] = 0;
    if (e_hit && !m_dyn[w] && m_chan[w] == 2'b11) m_tk[w] = 1;
    if (cmd_valid) begin
      m_act[cmd_buf] = 1; m_dir[cmd_buf] = m_sdir; m_dyn[cmd_buf] = m_sdyn;
      m_slot[cmd_buf] = m_sslot; m_chan[cmd_buf] = m_schan;
    end
    if (stg_wr) begin
      m_sdir = stg_dir; m_sdyn = stg_dyn; m_sslot = stg_slot; m_schan = stg_chan;
    end
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (hit !== e_hit || hit_idx !== e_idx) begin
      errors++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, hit, hit_idx, e_hit, e_idx);
    end
    stg_wr = 0; cmd_valid = 0; slot_start = 0; frm_valid = 0;
  endtask

  task automatic load(int b, logic d, int s, logic dy, logic [1:0] c);
    stg_wr = 1; stg_dir = d; stg_slot = SLOT_W'(s); stg_dyn = dy; stg_chan = c;
    cyc("R3");
    cmd_valid = 1; cmd_buf = IDX_W'(b);
    cyc("R2");
  endtask

  task automatic frame(int s, logic ch, logic dy, logic ok, string tag);
    frm_valid = 1; frm_slot = SLOT_W'(s); frm_chan = ch; frm_dyn = dy; frm_ok = ok;
    cyc(tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1");
    frame(0, 0, 0, 1, "R1");
    // R3: staged but uncommitted
    stg_wr = 1; stg_slot = 11'd5; stg_chan = 2'b01; cyc("R3");
    frame(5, 0, 0, 1, "R3");
    // R2: commit in same cycle as frame judged on old table
    cmd_valid = 1; cmd_buf = 3'd4; frm_valid = 1; frm_slot = 11'd5; frm_ok = 1; frm_chan = 0; frm_dyn = 0;
    cyc("R2");
    frame(5, 0, 0, 1, "R2");
    // R4
    load(1, 1, 9, 0, 2'b11);
    frame(9, 0, 0, 1, "R4");
    // R5
    load(2, 0, 12, 1, 2'b10);
    frame(12, 0, 1, 1, "R5");
    frame(12, 1, 0, 1, "R5");
    frame(12, 1, 1, 1, "R5");
    // R6
    load(3, 0, 14, 1, 2'b11);
    frame(14, 0, 1, 1, "R6");
    // R7 and R8
    load(6, 0, 20, 0, 2'b10);
    load(0, 0, 20, 0, 2'b11);
    slot_start = 1; cyc("R7");
    frame(20, 0, 0, 0, "R9");
    frame(20, 0, 0, 1, "R7");
    frame(20, 0, 0, 1, "R7");
    frame(20, 1, 0, 1, "R8");
    slot_start = 1; frm_valid = 1; frm_slot = 11'd20; frm_chan = 1; frm_dyn = 0; frm_ok = 1;
    cyc("R7");
    frame(20, 1, 0, 1, "R8");
    cyc("R10");
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 10) begin
        stg_wr = 1; stg_dir = ($urandom_range(0, 7) == 0); stg_slot = SLOT_W'($urandom_range(0, 5));
        stg_dyn = $urandom_range(0, 1); stg_chan = 2'($urandom_range(0, 3));
      end
      if (r >= 10 && r < 18) begin cmd_valid = 1; cmd_buf = IDX_W'($urandom_range(0, NBUF - 1)); end
      if ($urandom_range(0, 9) == 0) slot_start = 1;
      if ($urandom_range(0, 9) < 6) begin
        frm_valid = 1; frm_slot = SLOT_W'($urandom_range(0, 5)); frm_chan = $urandom_range(0, 1);
        frm_dyn = $urandom_range(0, 1); frm_ok = ($urandom_range(0, 7) != 0);
      end
      cyc("R5");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule